// File: doc/BRIEF.md
# CAN Receive Mailbox Acceptance Filter

This block sits behind a CAN protocol engine and decides where a completed, valid received frame goes. The frame arrives on a valid/ready stream as one beat carrying the 29-bit identifier, the extended-format flag, the remote-request flag, the length code and eight data bytes. The block then walks the mailboxes one per clock. It stops at the first mailbox whose filter accepts the frame, writes the frame into that mailbox and raises that mailbox's pending flag. If the flag was already set, the old contents are overwritten and a lost flag is raised as well. A level interrupt stays high while any mailbox that has its interrupt enabled is pending.

The general mailboxes are searched from the lowest index upward, and only those configured for reception take part. The highest mailbox receives only and is tried last, so it acts as a catch-all. Each mailbox can apply a shared global mask, a shared local mask, both or neither to its identifier comparison. A CPU sees every mailbox and the two masks through a word-addressed register port with combinational read data. It clears the pending and lost flags by writing ones.

Back-pressure: `in_ready` is high only while no search is running. A frame is taken on a clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, the source must hold the frame and keep `in_valid` high. A full search over 32 mailboxes takes at most 32 cycles, which fits inside the interframe gap.

Top module: `can_rx_filter`

## Requirements
- R1: After reset, the pending and lost flags, all mailbox words and both masks read 0, `irq` and `busy` are 0, and `in_ready` is 1.
- R2: Of the general mailboxes 0 to NUM_MB-2, only those with the receive-enable bit (bit 8 of mailbox word 1) set to 1 are compared with a frame.
- R3: A frame matches a mailbox when the IDE flags are equal and ((frame_id XOR mailbox_id) AND NOT M) is 0. M is the global mask if the mailbox's global-enable bit (word 0 bit 30) is set, ORed with the local mask if its local-enable bit (word 0 bit 31) is set. With neither bit set, M is 0 and the identifier must match exactly. Mailbox word 0 holds the identifier in bits 28:0 and IDE in bit 29.
- R4: The lowest-numbered matching mailbox receives the frame. No other mailbox changes.
- R5: Mailbox NUM_MB-1 always receives, whatever its enable bit says. It is compared only when no general mailbox matched.
- R6: On a match, the mailbox's identifier and IDE are replaced by the frame's. Word 1 bits 3:0 take the DLC and bit 4 takes RTR. Word 2 holds data bytes 0 to 3 and word 3 holds bytes 4 to 7, byte 0 in bits 7:0. The mailbox's pending bit becomes 1.
- R7: A frame that matches no mailbox changes no mailbox word and no flag.
- R8: When a frame is written into a mailbox whose pending bit is already 1, that mailbox's lost bit becomes 1 and its contents are overwritten.
- R9: The masks are at addresses 0x80 (global) and 0x81 (local). Pending is at 0x82 and lost is at 0x83, with bit n for mailbox n. Writing 1 to a bit of pending or lost clears that bit, and writing 0 leaves it unchanged. Mailbox n word w is at address 4n+w.
- R10: `irq` is 1 exactly when some mailbox has both its pending bit and its interrupt-enable bit (word 1 bit 9) set.
- R11: A frame is accepted when `in_valid` and `in_ready` are both high at a clock edge. After that edge `busy` is high and `in_ready` is low. If mailbox k is the winner, the result is visible and `busy` is low after k+1 further edges. With no winner, this takes NUM_MB edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Received frame present |
| in_ready | output | 1 | Filter idle, frame can be taken |
| in_id | input | 29 | Frame identifier |
| in_ide | input | 1 | Extended-format flag |
| in_rtr | input | 1 | Remote-request flag |
| in_dlc | input | 4 | Data length code |
| in_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| reg_addr | input | ADDR_W | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| busy | output | 1 | Search in progress |
| irq | output | 1 | Receive-complete interrupt, level |

## Verification
The bench sets several mailboxes to the same identifier. This catches a design that picks the highest match instead of the lowest, that stores into disabled mailboxes, or that writes into more than one mailbox. It also steers frames at the catch-all mailbox both with and without an earlier match, which exposes a design that lets the catch-all win while a general mailbox matches. Mask cases cover a match through each mask alone and an IDE mismatch under a mask that would otherwise accept the frame. A design that masks IDE, or that ignores which mask a mailbox enables, would store frames it should reject. Repeat frames to a pending mailbox check the lost flag and the overwrite, and back-to-back frames check that the second frame waits for `in_ready` while the search length is compared cycle by cycle.

// File: rtl/can_rxf_pkg.sv
package can_rxf_pkg;
  localparam int CAN_ID_W   = 29;
  localparam int CAN_DLC_W  = 4;
  localparam int CAN_DATA_W = 64;
  localparam int REG_W      = 32;

  typedef struct packed {
    logic [CAN_ID_W-1:0]   id;
    logic                  ide;
    logic                  rtr;
    logic [CAN_DLC_W-1:0]  dlc;
    logic [CAN_DATA_W-1:0] data;
  } rx_frame_t;
endpackage

// File: rtl/can_rxf_match.sv
module can_rxf_match
  import can_rxf_pkg::*;
(
  input  logic [CAN_ID_W-1:0] frm_id,
  input  logic                frm_ide,
  input  logic [CAN_ID_W-1:0] box_id,
  input  logic                box_ide,
  input  logic                use_glb,
  input  logic                use_loc,
  input  logic [CAN_ID_W-1:0] glb_mask,
  input  logic [CAN_ID_W-1:0] loc_mask,
  output logic                hit
);
  logic [CAN_ID_W-1:0] dont_care;

  always_comb begin
    dont_care = (use_glb ? glb_mask : '0) | (use_loc ? loc_mask : '0);
    hit = (frm_ide == box_ide) && (((frm_id ^ box_id) & ~dont_care) == '0);
  end
endmodule

// File: rtl/can_rxf_scan.sv
module can_rxf_scan #(
  parameter int NUM_MB = 32,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             cand_rx,
  input  logic             cand_hit,
  output logic             in_ready,
  output logic             busy,
  output logic             load,
  output logic [IDX_W-1:0] idx,
  output logic             win
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_MB - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic             eligible;

  always_comb begin
    eligible = cand_rx || (idx_q == LAST);
    win      = busy_q && cand_hit && eligible;
    in_ready = !busy_q;
    load     = in_valid && !busy_q;
    busy     = busy_q;
    idx      = idx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (in_valid) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end
    end else if (win || idx_q == LAST) begin
      busy_q <= 1'b0;
    end else begin
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/can_rxf_store.sv
module can_rxf_store
  import can_rxf_pkg::*;
#(
  parameter int NUM_MB = 32,
  localparam int IDX_W  = $clog2(NUM_MB),
  localparam int ADDR_W = IDX_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [IDX_W-1:0]  cur_idx,
  output logic [CAN_ID_W-1:0] cur_id,
  output logic              cur_ide,
  output logic              cur_glb,
  output logic              cur_loc,
  output logic              cur_rx,
  output logic [CAN_ID_W-1:0] glb_mask,
  output logic [CAN_ID_W-1:0] loc_mask,
  input  logic              win,
  input  rx_frame_t         frm,
  output logic [NUM_MB-1:0] pend,
  output logic [NUM_MB-1:0] lost,
  output logic [NUM_MB-1:0] ien
);
  logic [CAN_ID_W-1:0]   id_q   [NUM_MB];
  logic [CAN_DLC_W-1:0]  dlc_q  [NUM_MB];
  logic [CAN_DATA_W-1:0] data_q [NUM_MB];
  logic [NUM_MB-1:0]     ide_q, rtr_q, glb_q, loc_q, rx_q, ie_q;
  logic [NUM_MB-1:0]     pend_q, lost_q, set_v, pclr, lclr;
  logic [CAN_ID_W-1:0]   gm_q, lm_q;

  logic                  glob_sp;
  logic [IDX_W-1:0]      sel;
  logic [1:0]            word;

  always_comb begin
    glob_sp = reg_addr[ADDR_W-1];
    sel     = reg_addr[IDX_W+1:2];
    word    = reg_addr[1:0];
    set_v   = win ? (NUM_MB'(1) << cur_idx) : '0;
    pclr    = (reg_we && glob_sp && word == 2'd2) ? reg_wdata[NUM_MB-1:0] : '0;
    lclr    = (reg_we && glob_sp && word == 2'd3) ? reg_wdata[NUM_MB-1:0] : '0;
    cur_id  = id_q[cur_idx];
    cur_ide = ide_q[cur_idx];
    cur_glb = glb_q[cur_idx];
    cur_loc = loc_q[cur_idx];
    cur_rx  = rx_q[cur_idx];
    glb_mask = gm_q;
    loc_mask = lm_q;
    pend    = pend_q;
    lost    = lost_q;
    ien     = ie_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (!glob_sp) begin
      case (word)
        2'd0: reg_rdata = {loc_q[sel], glb_q[sel], ide_q[sel], id_q[sel]};
        2'd1: begin
          reg_rdata[CAN_DLC_W-1:0] = dlc_q[sel];
          reg_rdata[4] = rtr_q[sel];
          reg_rdata[8] = rx_q[sel];
          reg_rdata[9] = ie_q[sel];
        end
        2'd2: reg_rdata = data_q[sel][31:0];
        default: reg_rdata = data_q[sel][63:32];
      endcase
    end else begin
      case (word)
        2'd0: reg_rdata[CAN_ID_W-1:0] = gm_q;
        2'd1: reg_rdata[CAN_ID_W-1:0] = lm_q;
        2'd2: reg_rdata[NUM_MB-1:0] = pend_q;
        default: reg_rdata[NUM_MB-1:0] = lost_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_MB; i++) begin
        id_q[i]   <= '0;
        dlc_q[i]  <= '0;
        data_q[i] <= '0;
      end
      ide_q  <= '0;
      rtr_q  <= '0;
      glb_q  <= '0;
      loc_q  <= '0;
      rx_q   <= '0;
      ie_q   <= '0;
      pend_q <= '0;
      lost_q <= '0;
      gm_q   <= '0;
      lm_q   <= '0;
    end else begin
      if (reg_we && !glob_sp) begin
        if (word == 2'd0) begin
          id_q[sel]  <= reg_wdata[CAN_ID_W-1:0];
          ide_q[sel] <= reg_wdata[29];
          glb_q[sel] <= reg_wdata[30];
          loc_q[sel] <= reg_wdata[31];
        end else if (word == 2'd1) begin
          rx_q[sel] <= reg_wdata[8];
          ie_q[sel] <= reg_wdata[9];
        end
      end
      if (reg_we && glob_sp && word == 2'd0) gm_q <= reg_wdata[CAN_ID_W-1:0];
      if (reg_we && glob_sp && word == 2'd1) lm_q <= reg_wdata[CAN_ID_W-1:0];
      if (win) begin
        id_q[cur_idx]   <= frm.id;
        ide_q[cur_idx]  <= frm.ide;
        rtr_q[cur_idx]  <= frm.rtr;
        dlc_q[cur_idx]  <= frm.dlc;
        data_q[cur_idx] <= frm.data;
      end
      pend_q <= (pend_q & ~pclr) | set_v;
      lost_q <= (lost_q & ~lclr) | (set_v & pend_q);
    end
  end
endmodule

// File: rtl/can_rx_filter.sv
module can_rx_filter
  import can_rxf_pkg::*;
#(
  parameter int NUM_MB = 32,
  localparam int IDX_W  = $clog2(NUM_MB),
  localparam int ADDR_W = IDX_W + 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [CAN_ID_W-1:0]   in_id,
  input  logic                  in_ide,
  input  logic                  in_rtr,
  input  logic [CAN_DLC_W-1:0]  in_dlc,
  input  logic [CAN_DATA_W-1:0] in_data,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_we,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  output logic                  busy,
  output logic                  irq
);
  rx_frame_t           frm_q;
  logic                load, win, hit;
  logic [IDX_W-1:0]    idx;
  logic [CAN_ID_W-1:0] cur_id, gmask, lmask;
  logic                cur_ide, cur_glb, cur_loc, cur_rx;
  logic [NUM_MB-1:0]   pend_q, lost_q, ien;

  always_ff @(posedge clk) begin
    if (rst) frm_q <= '0;
    else if (load) frm_q <= '{id: in_id, ide: in_ide, rtr: in_rtr, dlc: in_dlc, data: in_data};
  end

  can_rxf_scan #(.NUM_MB(NUM_MB)) u_scan (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cand_rx(cur_rx), .cand_hit(hit),
    .in_ready(in_ready), .busy(busy), .load(load), .idx(idx), .win(win)
  );

  can_rxf_match u_match (
    .frm_id(frm_q.id), .frm_ide(frm_q.ide), .box_id(cur_id), .box_ide(cur_ide),
    .use_glb(cur_glb), .use_loc(cur_loc), .glb_mask(gmask), .loc_mask(lmask), .hit(hit)
  );

  can_rxf_store #(.NUM_MB(NUM_MB)) u_store (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cur_idx(idx), .cur_id(cur_id), .cur_ide(cur_ide),
    .cur_glb(cur_glb), .cur_loc(cur_loc), .cur_rx(cur_rx), .glb_mask(gmask),
    .loc_mask(lmask), .win(win), .frm(frm_q), .pend(pend_q), .lost(lost_q), .ien(ien)
  );

  assign irq = |(pend_q & ien);
endmodule

// File: rtl/can_rx_filter_chk.sv
module can_rx_filter_chk #(
  parameter int NUM_MB = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              busy,
  input logic [NUM_MB-1:0] pend,
  input logic [NUM_MB-1:0] lost
);
  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (rst) run_len <= 0;
    else run_len <= busy ? run_len + 1 : 0;
  end

  AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (rst) busy |-> run_len < NUM_MB); // R11
  AST_START_ON_VALID: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(in_valid)); // R11
  AST_ONE_BOX_SET: assert property (@(posedge clk) disable iff (rst) $countones(pend & ~$past(pend)) <= 1); // R4
  AST_SET_AFTER_SCAN: assert property (@(posedge clk) disable iff (rst) (|(pend & ~$past(pend))) |-> $past(busy)); // R7
  AST_LOST_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst) ((lost & ~$past(lost)) & ~$past(pend)) == '0); // R8
endmodule

bind can_rx_filter can_rx_filter_chk #(.NUM_MB(NUM_MB)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .busy(busy), .pend(pend_q), .lost(lost_q)
);

// File: tb/can_rx_filter_tb.sv
module can_rx_filter_tb;
  localparam int NUM_MB = 32;
  localparam int AW = 8;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_ready, in_ide = 0, in_rtr = 0, busy, irq, reg_we = 0;
  logic [28:0] in_id = '0;
  logic [3:0]  in_dlc = '0;
  logic [63:0] in_data = '0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;

  always #4 clk = ~clk;

  can_rx_filter #(.NUM_MB(NUM_MB)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_id(in_id),
    .in_ide(in_ide), .in_rtr(in_rtr), .in_dlc(in_dlc), .in_data(in_data),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .irq(irq)
  );

  int errors = 0, checks = 0;
  bit started = 0, done = 0;

  // reference model state
  logic [28:0] m_id [NUM_MB];
  logic [3:0]  m_dlc [NUM_MB];
  logic [63:0] m_data [NUM_MB];
  logic [NUM_MB-1:0] m_ide, m_rtr, m_glb, m_loc, m_rx, m_ie, m_pend, m_lost;
  logic [28:0] m_gm, m_lm, f_id;
  logic f_ide, f_rtr;
  logic [3:0] f_dlc;
  logic [63:0] f_data;
  bit m_busy;
  int m_cnt, m_win;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit m_match(int k);
    logic [28:0] m;
    m = (m_glb[k] ? m_gm : 29'd0) | (m_loc[k] ? m_lm : 29'd0);
    return (f_ide == m_ide[k]) && (((f_id ^ m_id[k]) & ~m) == 29'd0);
  endfunction

  function automatic int m_find();
    for (int k = 0; k < NUM_MB; k++)
      if ((k == NUM_MB - 1 || m_rx[k]) && m_match(k)) return k;
    return -1;
  endfunction

  function automatic logic [31:0] m_read(logic [AW-1:0] a);
    int n;
    n = int'(a[AW-2:2]);
    if (!a[AW-1]) begin
      case (a[1:0])
        2'd0: return {m_loc[n], m_glb[n], m_ide[n], m_id[n]};
        2'd1: return {22'd0, m_ie[n], m_rx[n], 3'd0, m_rtr[n], m_dlc[n]};
        2'd2: return m_data[n][31:0];
        default: return m_data[n][63:32];
      endcase
    end
    case (a[1:0])
      2'd0: return {3'd0, m_gm};
      2'd1: return {3'd0, m_lm};
      2'd2: return m_pend;
      default: return m_lost;
    endcase
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      for (int i = 0; i < NUM_MB; i++) begin m_id[i] = 0; m_dlc[i] = 0; m_data[i] = 0; end
      m_ide = 0; m_rtr = 0; m_glb = 0; m_loc = 0; m_rx = 0; m_ie = 0;
      m_pend = 0; m_lost = 0; m_gm = 0; m_lm = 0; m_busy = 0; m_cnt = 0; m_win = -1;
    end else begin
      if (reg_we) begin
        int n;
        n = int'(reg_addr[AW-2:2]);
        if (!reg_addr[AW-1]) begin
          if (reg_addr[1:0] == 0) begin
            m_id[n] = reg_wdata[28:0]; m_ide[n] = reg_wdata[29];
            m_glb[n] = reg_wdata[30]; m_loc[n] = reg_wdata[31];
          end else if (reg_addr[1:0] == 1) begin
            m_rx[n] = reg_wdata[8]; m_ie[n] = reg_wdata[9];
          end
        end else begin
          case (reg_addr[1:0])
            2'd0: m_gm = reg_wdata[28:0];
            2'd1: m_lm = reg_wdata[28:0];
            2'd2: m_pend = m_pend & ~reg_wdata;
            default: m_lost = m_lost & ~reg_wdata;
          endcase
        end
      end
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0;
          if (m_win >= 0) begin
            if (m_pend[m_win]) m_lost[m_win] = 1'b1;
            m_pend[m_win] = 1'b1;
            m_id[m_win] = f_id; m_ide[m_win] = f_ide; m_rtr[m_win] = f_rtr;
            m_dlc[m_win] = f_dlc; m_data[m_win] = f_data;
          end
        end
      end else if (in_valid) begin
        f_id = in_id; f_ide = in_ide; f_rtr = in_rtr; f_dlc = in_dlc; f_data = in_data;
        m_win = m_find();
        m_cnt = (m_win >= 0) ? m_win + 1 : NUM_MB;
        m_busy = 1;
      end
    end
  end

  // every-cycle comparison of the stream and status pins
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R11 busy", busy, m_busy);
      chk("R11 in_ready", in_ready, !m_busy);
      chk("R10 irq", irq, |(m_pend & m_ie));
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(string tag, logic [AW-1:0] a);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, m_read(a));
  endtask

  task automatic rd_lit(string tag, logic [AW-1:0] a, logic [31:0] e);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, e);
  endtask

  task automatic send(logic [28:0] id, logic ide, logic rtr, logic [3:0] dlc, logic [63:0] d, bit wait_idle);
    bit ok;
    @(negedge clk);
    in_valid = 1; in_id = id; in_ide = ide; in_rtr = rtr; in_dlc = dlc; in_data = d;
    do begin
      #1 ok = in_ready;
      @(negedge clk);
    end while (!ok);
    in_valid = 0;
    if (wait_idle) while (m_busy) @(negedge clk);
  endtask

  function automatic logic [AW-1:0] mb(int n, int w);
    return AW'(4 * n + w);
  endfunction

  localparam logic [AW-1:0] A_GM = 8'h80, A_LM = 8'h81, A_PND = 8'h82, A_LST = 8'h83;

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd_lit("R1 pending", A_PND, 0);
    rd_lit("R1 lost", A_LST, 0);
    rd_lit("R1 mb0 id", mb(0, 0), 0);
    rd_lit("R1 mb5 ctl", mb(5, 1), 0);
    rd_lit("R1 gmask", A_GM, 0);

    // R2/R4: mb2 same id but disabled, mb3 and mb7 enabled
    wr(mb(2, 0), 32'h123);
    wr(mb(3, 0), 32'h123); wr(mb(3, 1), 32'h300);
    wr(mb(7, 0), 32'h123); wr(mb(7, 1), 32'h100);
    send(29'h123, 0, 0, 4'd8, 64'h0807060504030201, 1);
    rd_lit("R4 lowest wins", A_PND, 32'h8);
    rd_lit("R6 data lo", mb(3, 2), 32'h04030201);
    rd_lit("R6 data hi", mb(3, 3), 32'h08070605);
    rd_lit("R6 ctl", mb(3, 1), 32'h308);
    rd("R2 disabled mb2 untouched", mb(2, 1));
    rd("R4 mb7 untouched", mb(7, 2));

    // R7: no match anywhere
    send(29'h555, 0, 1, 4'd2, 64'hAA, 1);
    rd_lit("R7 pending unchanged", A_PND, 32'h8);
    rd_lit("R7 mb31 unchanged", mb(31, 0), 0);

    // R3: global mask, IDE exact, local mask, exact compare
    wr(A_GM, 32'hFF);
    wr(A_LM, 32'hF00);
    wr(mb(10, 0), 32'h6000_0000 | 32'h1000_0000);
    wr(mb(10, 1), 32'h100);
    send(29'h1000_0042, 1, 0, 4'd1, 64'h11, 1);
    rd_lit("R3 global mask hit", A_PND, 32'h408);
    rd_lit("R3 stored id", mb(10, 0), 32'h7000_0042);
    send(29'h1000_0043, 0, 0, 4'd1, 64'h22, 1);
    rd_lit("R3 ide must match", A_PND, 32'h408);
    wr(mb(12, 0), 32'h8000_0300);
    wr(mb(12, 1), 32'h100);
    send(29'hA00, 0, 0, 4'd3, 64'h333, 1);
    rd_lit("R3 local mask hit", A_PND, 32'h1408);
    send(29'h122, 0, 0, 4'd3, 64'h444, 1);
    rd_lit("R3 exact miss", A_PND, 32'h1408);

    // R5: catch-all mailbox
    wr(mb(31, 0), 32'h77);
    send(29'h77, 0, 0, 4'd4, 64'h5555, 1);
    rd_lit("R5 catch-all", A_PND, 32'h8000_1408);
    wr(A_PND, 32'h8000_0000);
    wr(mb(20, 0), 32'h77); wr(mb(20, 1), 32'h100);
    send(29'h77, 0, 0, 4'd5, 64'h6666, 1);
    rd_lit("R5 general first", A_PND, 32'h0010_1408);

    // R8: overwrite of pending mailbox
    send(29'h123, 0, 1, 4'd2, 64'hBEEF, 1);
    rd_lit("R8 lost", A_LST, 32'h8);
    rd_lit("R8 overwrite", mb(3, 2), 32'hBEEF);
    rd("R8 ctl", mb(3, 1));

    // R9: write-one-to-clear
    wr(A_LST, 32'h8);
    rd_lit("R9 lost cleared", A_LST, 0);
    wr(A_PND, 32'h0000_0008);
    rd_lit("R9 pending partial", A_PND, 32'h0010_1400);
    // R10: only mb12 left without enable... clear others
    wr(A_PND, 32'h0010_0400);
    rd_lit("R9 remaining", A_PND, 32'h1000);
    chk("R10 irq off with disabled pending", irq, 0);
    wr(A_PND, 32'hFFFF_FFFF);

    // R11: back-to-back frames, second held off while busy
    send(29'h123, 0, 0, 4'd1, 64'h1, 0);
    send(29'h77, 0, 0, 4'd1, 64'h2, 1);
    rd_lit("R11 both stored", A_PND, 32'h0010_0008);
    rd("R11 mb20 data", mb(20, 2));

    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule